// File: doc/BRIEF.md
# Coherence Directory Controller

This block sits at the home node of a distributed shared memory machine. It owns a range of memory blocks. For every block it keeps a coherence state and a vector with one bit per processor that records which caches hold a copy. Cache controllers send it read misses, write misses and write-backs. It answers each one by updating the entry and by sending point-to-point traffic: invalidates to sharers, fetch or fetch-and-invalidate requests to an owner, and a data reply to the requester. The reply data comes from the block's local memory array. No bus is snooped: every copy is reached through the sharer vector.

Three valid/ready streams connect the block to the network. The request stream carries the incoming miss and write-back messages. The outgoing stream carries every message the controller emits. The response stream returns data from an owner after a fetch. A transfer happens on a rising clock edge when valid and ready are both high. Rules for senders to the block: once valid is high, the message fields stay stable until the transfer. The block obeys the same rule on its outgoing stream, so a stalled message keeps all its fields. The block handles one transaction at a time. It lowers `req_ready` from the edge that accepts a request until the last outgoing message of that transaction has transferred. It raises `rsp_ready` only while it waits for fetched data.

Top module: `coh_dir_home`

## Requirements
- R1: After reset every block is uncached with an empty sharer vector and every memory word is zero, `req_ready` is high, and `out_valid` and `rsp_ready` are low.
- R2: A read miss (req_kind 0) to an uncached or shared block produces exactly one message: a data reply (out_kind 0) to the requester that carries the block's memory value. The requester is added to the sharer vector and the block becomes shared.
- R3: A read miss to a block held exclusively by another node first sends a fetch (out_kind 2) to the owner. The controller then waits for the response stream, writes the returned value to memory and replies with that value. The block becomes shared, with the old owner and the requester as its sharers.
- R4: A write miss (req_kind 1) to a shared block sends one invalidate (out_kind 1) to each sharer other than the requester, in ascending node order, and then a data reply with the memory value. The block becomes exclusive, with the requester as the only sharer.
- R5: A write miss to a block held exclusively by another node sends a fetch-and-invalidate (out_kind 3) to the owner. The returned value is written to memory and sent to the requester in a data reply. The requester becomes the only sharer of an exclusive block.
- R6: A write miss to an uncached block produces only a data reply with the memory value, and the requester becomes the exclusive owner.
- R7: A write-back (req_kind 2) from the exclusive owner writes its data into memory and leaves the block uncached with an empty sharer vector. A write-back from any other node, and any request with req_kind 3, is dropped: no message is sent and neither memory nor the entry changes.
- R8: A read or write miss from the node that already owns the block exclusively produces only a data reply with the memory value. No fetch is sent and the entry is unchanged.
- R9: Only one transaction is open at a time. `req_ready` stays low from the acceptance of a request until that transaction's final message has transferred. `rsp_ready` is high only while the controller waits for fetched data, and no outgoing message is offered during that wait.
- R10: While `out_valid` is high and `out_ready` is low, every outgoing field stays stable. Messages other than data replies carry zero in `out_data`. Within one transaction the order is invalidates, then any fetch, then the reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Incoming request offered |
| req_ready | output | 1 | Controller accepts a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 dropped |
| req_node | input | NW | Requesting processor id |
| req_addr | input | AW | Block address |
| req_data | input | DW | Block value carried by a write-back |
| rsp_valid | input | 1 | Fetched data offered by the owner |
| rsp_ready | output | 1 | Controller waits for fetched data |
| rsp_data | input | DW | Fetched block value |
| out_valid | output | 1 | Outgoing message offered |
| out_ready | input | 1 | Network accepts the outgoing message |
| out_kind | output | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| out_node | output | NW | Destination processor id |
| out_addr | output | AW | Block address |
| out_data | output | DW | Block value for replies, zero otherwise |

## Verification
The bound assertions check the stream rules on every cycle: a stalled outgoing message must hold its fields, `req_ready` must stay low while a transaction is open, `rsp_ready` must be exclusive with outgoing traffic, a fetch transfer must be followed by a wait for data, and fetched data must go out unchanged in the next reply. They cannot see whether the directory entry took the right state or sharer set. Only the bench's scenarios show that. It keeps its own model of states, sharers and memory, and predicts the exact sequence of invalidates, fetches and replies for chains of requests: shared blocks that gather sharers, ownership that passes between nodes, write-backs from owners and from non-owners, and repeat requests from an owner.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
  typedef enum logic [1:0] {
    DIR_UNC = 2'd0,
    DIR_SHR = 2'd1,
    DIR_EXC = 2'd2
  } dir_state_e;

  typedef enum logic [2:0] {
    C_IDLE,
    C_EVAL,
    C_INV,
    C_FETCH,
    C_WAIT,
    C_REPLY
  } ctl_state_e;

  localparam logic [1:0] REQ_RD = 2'd0;
  localparam logic [1:0] REQ_WR = 2'd1;
  localparam logic [1:0] REQ_WB = 2'd2;

  localparam logic [1:0] MSG_REPLY    = 2'd0;
  localparam logic [1:0] MSG_INV      = 2'd1;
  localparam logic [1:0] MSG_FETCH    = 2'd2;
  localparam logic [1:0] MSG_FETCHINV = 2'd3;
endpackage

// File: rtl/coh_dir_pick.sv
module coh_dir_pick #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] idx,
  output logic         any
);
  always_comb begin
    idx = '0;
    any = |vec;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/coh_dir_table.sv
module coh_dir_table
  import coh_dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 16,
  parameter int DW     = 16,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  output dir_state_e        rd_state,
  output logic [NODES-1:0]  rd_sharers,
  output logic [DW-1:0]     rd_data,
  input  logic              ent_we,
  input  dir_state_e        wr_state,
  input  logic [NODES-1:0]  wr_sharers,
  input  logic              mem_we,
  input  logic [DW-1:0]     wr_data
);
  dir_state_e       st_q [BLOCKS];
  logic [NODES-1:0] sh_q [BLOCKS];
  logic [DW-1:0]    mem_q[BLOCKS];

  assign rd_state   = st_q[addr];
  assign rd_sharers = sh_q[addr];
  assign rd_data    = mem_q[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BLOCKS; i++) begin
        st_q[i] <= DIR_UNC;
        sh_q[i] <= '0;
      end
    end else if (ent_we) begin
      st_q[addr] <= wr_state;
      sh_q[addr] <= wr_sharers;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BLOCKS; i++) mem_q[i] <= '0;
    end else if (mem_we) begin
      mem_q[addr] <= wr_data;
    end
  end
endmodule

// File: rtl/coh_dir_home.sv
module coh_dir_home
  import coh_dir_pkg::*;
#(
  parameter int  NODES  = 4,
  parameter int  BLOCKS = 16,
  parameter int  DW     = 16,
  localparam int NW     = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int AW     = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [NW-1:0] req_node,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [DW-1:0] rsp_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [1:0]    out_kind,
  output logic [NW-1:0] out_node,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data
);
  ctl_state_e       ctl_q;
  logic [1:0]       kind_q;
  logic [NW-1:0]    node_q;
  logic [NW-1:0]    owner_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [DW-1:0]    reply_q;
  logic [NODES-1:0] pend_q;
  logic             finv_q;

  dir_state_e       ent_state;
  logic [NODES-1:0] ent_shr;
  logic [DW-1:0]    mem_rd;
  logic             ent_we, mem_we;
  dir_state_e       new_state;
  logic [NODES-1:0] new_shr;
  logic [DW-1:0]    mem_wd;

  logic [NODES-1:0] req_oh, own_oh;
  logic [NW-1:0]    own_idx, inv_idx;
  logic             own_any, inv_any;
  logic             is_owner, other_owner;

  coh_dir_table #(.NODES(NODES), .BLOCKS(BLOCKS), .DW(DW), .AW(AW)) u_table (
    .clk(clk), .rst_n(rst_n), .addr(addr_q),
    .rd_state(ent_state), .rd_sharers(ent_shr), .rd_data(mem_rd),
    .ent_we(ent_we), .wr_state(new_state), .wr_sharers(new_shr),
    .mem_we(mem_we), .wr_data(mem_wd)
  );

  coh_dir_pick #(.N(NODES), .W(NW)) u_own_pick (
    .vec(ent_shr), .idx(own_idx), .any(own_any)
  );

  coh_dir_pick #(.N(NODES), .W(NW)) u_inv_pick (
    .vec(pend_q), .idx(inv_idx), .any(inv_any)
  );

  always_comb begin
    req_oh = '0;
    req_oh[node_q] = 1'b1;
    own_oh = '0;
    own_oh[owner_q] = 1'b1;
  end

  assign is_owner    = (ent_state == DIR_EXC) && (ent_shr == req_oh);
  assign other_owner = (ent_state == DIR_EXC) && own_any && !is_owner;

  // Directory and memory updates: decided in EVAL, or on fetched data in WAIT
  always_comb begin
    ent_we    = 1'b0;
    mem_we    = 1'b0;
    new_state = ent_state;
    new_shr   = ent_shr;
    mem_wd    = wdata_q;
    if (ctl_q == C_EVAL) begin
      if (kind_q == REQ_WB && is_owner) begin
        ent_we    = 1'b1;
        mem_we    = 1'b1;
        new_state = DIR_UNC;
        new_shr   = '0;
      end else if (kind_q == REQ_RD && ent_state != DIR_EXC) begin
        ent_we    = 1'b1;
        new_state = DIR_SHR;
        new_shr   = ent_shr | req_oh;
      end else if (kind_q == REQ_WR && ent_state != DIR_EXC) begin
        ent_we    = 1'b1;
        new_state = DIR_EXC;
        new_shr   = req_oh;
      end
    end else if (ctl_q == C_WAIT && rsp_valid) begin
      ent_we    = 1'b1;
      mem_we    = 1'b1;
      mem_wd    = rsp_data;
      new_state = finv_q ? DIR_EXC : DIR_SHR;
      new_shr   = finv_q ? req_oh : (req_oh | own_oh);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= C_IDLE;
      kind_q  <= '0;
      node_q  <= '0;
      owner_q <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      reply_q <= '0;
      pend_q  <= '0;
      finv_q  <= 1'b0;
    end else begin
      unique case (ctl_q)
        C_IDLE: if (req_valid) begin
          kind_q  <= req_kind;
          node_q  <= req_node;
          addr_q  <= req_addr;
          wdata_q <= req_data;
          ctl_q   <= C_EVAL;
        end
        C_EVAL: begin
          reply_q <= mem_rd;
          owner_q <= own_idx;
          finv_q  <= (kind_q == REQ_WR);
          pend_q  <= '0;
          if (kind_q != REQ_RD && kind_q != REQ_WR) begin
            ctl_q <= C_IDLE;
          end else if (other_owner) begin
            ctl_q <= C_FETCH;
          end else if (kind_q == REQ_WR && ent_state == DIR_SHR) begin
            pend_q <= ent_shr & ~req_oh;
            ctl_q  <= C_INV;
          end else begin
            ctl_q <= C_REPLY;
          end
        end
        C_INV: begin
          if (!inv_any) ctl_q <= C_REPLY;
          else if (out_ready) pend_q[inv_idx] <= 1'b0;
        end
        C_FETCH: if (out_ready) ctl_q <= C_WAIT;
        C_WAIT: if (rsp_valid) begin
          reply_q <= rsp_data;
          ctl_q   <= C_REPLY;
        end
        C_REPLY: if (out_ready) ctl_q <= C_IDLE;
        default: ctl_q <= C_IDLE;
      endcase
    end
  end

  assign req_ready = (ctl_q == C_IDLE);
  assign rsp_ready = (ctl_q == C_WAIT);
  assign out_addr  = addr_q;

  always_comb begin
    out_valid = 1'b0;
    out_kind  = MSG_REPLY;
    out_node  = node_q;
    out_data  = '0;
    unique case (ctl_q)
      C_INV: begin
        out_valid = inv_any;
        out_kind  = MSG_INV;
        out_node  = inv_idx;
      end
      C_FETCH: begin
        out_valid = 1'b1;
        out_kind  = finv_q ? MSG_FETCHINV : MSG_FETCH;
        out_node  = owner_q;
      end
      C_REPLY: begin
        out_valid = 1'b1;
        out_data  = reply_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/coh_dir_home_chk.sv
module coh_dir_home_chk
  import coh_dir_pkg::*;
#(
  parameter int  NODES  = 4,
  parameter int  BLOCKS = 16,
  parameter int  DW     = 16,
  localparam int NW     = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int AW     = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic          out_valid,
  input logic          out_ready,
  input logic [1:0]    out_kind,
  input logic [NW-1:0] out_node,
  input logic [AW-1:0] out_addr,
  input logic [DW-1:0] out_data
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_node)
                                && $stable(out_addr) && $stable(out_data));

  assert_nodata_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind != MSG_REPLY |-> out_data == '0);

  assert_serial_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);

  assert_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !req_ready && !out_valid);

  assert_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_kind[1] |=> rsp_ready);

  assert_forward_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> out_valid && out_kind == MSG_REPLY && out_data == $past(rsp_data));
endmodule

bind coh_dir_home coh_dir_home_chk #(.NODES(NODES), .BLOCKS(BLOCKS), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
  .out_node(out_node), .out_addr(out_addr), .out_data(out_data)
);

// File: tb/coh_dir_home_bench.sv
module coh_dir_home_bench;
  import coh_dir_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NODES = 4;
  localparam int BLOCKS = 16;
  localparam int DW = 16;
  localparam int NW = 2;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_kind = '0;
  logic [NW-1:0] req_node = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic rsp_valid = 1'b0;
  logic rsp_ready;
  logic [DW-1:0] rsp_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [1:0] out_kind;
  logic [NW-1:0] out_node;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;

  coh_dir_home #(.NODES(NODES), .BLOCKS(BLOCKS), .DW(DW)) u_coh_dir_home (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    logic [1:0]    kind;
    logic [NW-1:0] node;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  exp_t expq[$];
  int n_tests = 0;
  int n_fail = 0;
  bit bp_mode = 1'b0;
  bit done = 1'b0;

  // model: 0 uncached, 1 shared, 2 exclusive
  int               m_st[BLOCKS];
  logic [NODES-1:0] m_sh[BLOCKS];
  logic [DW-1:0]    m_mem[BLOCKS];

  bit fetch_req = 1'b0;
  logic [AW-1:0] f_addr;
  logic [NW-1:0] f_node;

  function automatic logic [DW-1:0] fval(int a, int n);
    return DW'(16'hF000) | DW'(a << 4) | DW'(n);
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(logic [1:0] k, int n, int a, logic [DW-1:0] d, string tag);
    exp_t e;
    e.kind = k; e.node = NW'(n); e.addr = AW'(a); e.data = d; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic send(logic [1:0] k, int n, int a, logic [DW-1:0] d, string tag);
    logic [NODES-1:0] oh;
    int own;
    oh = '0; oh[n] = 1'b1;
    own = 0;
    for (int i = NODES - 1; i >= 0; i--) if (m_sh[a][i]) own = i;
    if (k == REQ_RD) begin
      if (m_st[a] == 2 && m_sh[a] != oh) begin
        push(MSG_FETCH, own, a, '0, tag);
        push(MSG_REPLY, n, a, fval(a, own), tag);
        m_mem[a] = fval(a, own); m_st[a] = 1; m_sh[a] = oh | m_sh[a];
      end else if (m_st[a] == 2) begin
        push(MSG_REPLY, n, a, m_mem[a], tag);
      end else begin
        push(MSG_REPLY, n, a, m_mem[a], tag);
        m_st[a] = 1; m_sh[a] = m_sh[a] | oh;
      end
    end else if (k == REQ_WR) begin
      if (m_st[a] == 2 && m_sh[a] != oh) begin
        push(MSG_FETCHINV, own, a, '0, tag);
        push(MSG_REPLY, n, a, fval(a, own), tag);
        m_mem[a] = fval(a, own);
      end else if (m_st[a] == 2) begin
        push(MSG_REPLY, n, a, m_mem[a], tag);
      end else begin
        for (int i = 0; i < NODES; i++)
          if (m_sh[a][i] && i != n) push(MSG_INV, i, a, '0, tag);
        push(MSG_REPLY, n, a, m_mem[a], tag);
      end
      m_st[a] = 2; m_sh[a] = oh;
    end else if (k == REQ_WB) begin
      if (m_st[a] == 2 && m_sh[a] == oh) begin
        m_mem[a] = d; m_st[a] = 0; m_sh[a] = '0;
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_node = NW'(n); req_addr = AW'(a); req_data = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (expq.size() != 0 || !req_ready);
    repeat (3) @(negedge clk);
  endtask

  // back-pressure driver, changes away from the sampling edge
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      #2;
      cyc++;
      out_ready = bp_mode ? (cyc % 3 != 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    bit hold_v = 1'b0;
    logic [1:0] h_kind;
    logic [NW-1:0] h_node;
    logic [AW-1:0] h_addr;
    logic [DW-1:0] h_data;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (hold_v)
          chk(out_valid && out_kind == h_kind && out_node == h_node
              && out_addr == h_addr && out_data == h_data,
              "R10", "stalled message changed", {out_kind, out_node, out_addr, out_data},
              {h_kind, h_node, h_addr, h_data});
        hold_v = out_valid && !out_ready;
        h_kind = out_kind; h_node = out_node; h_addr = out_addr; h_data = out_data;
        if (out_valid && out_ready) begin
          if (expq.size() == 0) begin
            chk(1'b0, "R7", "unexpected message", {out_kind, out_node, out_addr, out_data}, 0);
          end else begin
            exp_t e;
            e = expq.pop_front();
            chk(out_kind == e.kind && out_node == e.node && out_addr == e.addr
                && out_data == e.data, e.tag, "message",
                {out_kind, out_node, out_addr, out_data}, {e.kind, e.node, e.addr, e.data});
          end
          if (out_kind[1]) begin
            fetch_req = 1'b1; f_addr = out_addr; f_node = out_node;
          end
        end
      end
    end
  end

  // owner model answering fetches after a delay
  initial begin
    forever begin
      @(negedge clk);
      if (fetch_req) begin
        fetch_req = 1'b0;
        repeat (4) @(negedge clk);
        chk(!req_ready && rsp_ready && !out_valid, "R9", "busy while waiting for data",
            {req_ready, rsp_ready, out_valid}, 3'b010);
        rsp_valid = 1'b1;
        rsp_data = fval(int'(f_addr), int'(f_node));
        while (!rsp_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < BLOCKS; i++) begin
      m_st[i] = 0; m_sh[i] = '0; m_mem[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !out_valid && !rsp_ready, "R1", "reset outputs",
        {req_ready, out_valid, rsp_ready}, 3'b100);

    // R1 / R2: reads of a reset block gather sharers
    send(REQ_RD, 0, 3, '0, "R1");
    send(REQ_RD, 1, 3, '0, "R2");
    send(REQ_RD, 2, 3, '0, "R2");
    drain();

    // R4: write miss to shared block, with back-pressure
    bp_mode = 1'b1;
    send(REQ_WR, 3, 3, '0, "R4");
    drain();

    // R3: read miss to exclusive, then R4 shows both nodes became sharers
    send(REQ_RD, 0, 3, '0, "R3");
    drain();
    send(REQ_WR, 1, 3, '0, "R4");
    drain();

    // R5: ownership moves
    send(REQ_WR, 2, 3, '0, "R5");
    drain();
    bp_mode = 1'b0;

    // R7: non-owner write-back dropped, owner write-back stored
    send(REQ_WB, 0, 3, 16'h5555, "R7");
    drain();
    send(REQ_WB, 2, 3, 16'h1234, "R7");
    drain();
    send(REQ_RD, 1, 3, '0, "R7");
    drain();

    // R6 / R8: uncached write miss, then owner repeats
    send(REQ_WR, 1, 7, '0, "R6");
    send(REQ_RD, 1, 7, '0, "R8");
    send(REQ_WR, 1, 7, '0, "R8");
    send(REQ_RD, 0, 7, '0, "R8");
    drain();

    // R7: kind 3 dropped at the top block address
    send(2'd3, 2, 15, 16'hBEEF, "R7");
    drain();
    send(REQ_RD, 2, 15, '0, "R7");
    drain();

    // R4: sole sharer upgrading sends no invalidates
    send(REQ_RD, 2, 5, '0, "R2");
    send(REQ_WR, 2, 5, '0, "R4");
    drain();

    chk(expq.size() == 0, "R10", "pending expected messages", expq.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule